// File: doc/BRIEF.md
# Multifunction Pin Mux and Drive Control

This block owns one general-purpose pad and decides, from a 4-bit role code, what the pad does. In an output role it picks one internal source (the host-written output bit, the interrupt line or the PDM clock) and turns that logical level into four pad controls: output enable, output data, weak pull-up enable and weak pull-down enable. A 3-bit drive code chooses how each level reaches the pad. It can drive the level strongly, hold it with a weak on-chip pull, or leave the pad floating. One field therefore gives push-pull, open-drain, open-source and weakly pulled outputs.

In an input role the pad is left undriven. Its level goes to exactly one consumer: master clock, daisy-chain data, either of two PDM data inputs, record power-down, or bias enable. In the general-purpose input role it goes instead to a monitor bit. The monitor bit reaches the host through a synchroniser. Two parameters strip the block down to an output-only or an input-only pin. Any role the pin variant cannot serve, and any unassigned role code, leaves the pad floating and routes nothing.

Top module: `pinmux_pin`

## Requirements
- R1: In an output role with drive code 3'b000, pad_oe, pad_pu_en and pad_pd_en are all 0 for either logical level.
- R2: With drive code 3'b001 in an output role, pad_oe is 1 and pad_out equals the logical level.
- R3: With drive code 3'b010, a low level gives pad_oe=1, pad_out=0. A high level gives pad_oe=0 and pad_pu_en=1.
- R4: With drive code 3'b011, a low level gives pad_oe=1, pad_out=0. A high level leaves pad_oe, pad_pu_en and pad_pd_en at 0.
- R5: With drive code 3'b100, a low level gives pad_oe=0 and pad_pd_en=1, and a high level gives pad_oe=1, pad_out=1. With drive code 3'b101, a low level floats the pad, and a high level gives pad_oe=1, pad_out=1.
- R6: Drive codes 3'b110 and 3'b111 leave pad_oe, pad_pu_en and pad_pd_en at 0.
- R7: Role code 1 takes the level from gpo_val, role 2 from irq_in, and role 4 from pdmclk_in.
- R8: In the input roles, pad_oe, pad_pu_en and pad_pd_en are 0, and pad_in is passed to exactly one consumer while all other route outputs stay 0. The role codes and their consumers are 3 to pwrdn_o, 5 to bias_en_o, 7 to mclk_o, 8 to chain_din_o, 9 to pdm_din0_o and 10 to pdm_din1_o. Role 6 (monitor) drives no route output.
- R9: Role 0 (disabled) and role codes 11 to 15 float the pad and hold every route output at 0.
- R10: In role 6, gpi_mon_o equals pad_in as sampled two rising edges earlier. In any other role it settles to 0 after two edges.
- R11: A low rst_n at a rising edge clears the monitor path, so gpi_mon_o is 0 on the next cycle.
- R12: pad_out is 0 whenever pad_oe is 0, and pad_pu_en and pad_pd_en are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the monitor synchroniser |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_func | input | 4 | Pin role code |
| cfg_drive | input | 3 | Drive style code |
| gpo_val | input | 1 | Host-written output level |
| irq_in | input | 1 | Internal interrupt level |
| pdmclk_in | input | 1 | Internal PDM clock |
| pad_in | input | 1 | Level seen at the pad |
| pad_oe | output | 1 | Strong driver enable |
| pad_out | output | 1 | Strong driver level |
| pad_pu_en | output | 1 | Weak pull-up enable |
| pad_pd_en | output | 1 | Weak pull-down enable |
| mclk_o | output | 1 | Master clock consumer |
| chain_din_o | output | 1 | Daisy-chain data consumer |
| pdm_din0_o | output | 1 | First PDM data consumer |
| pdm_din1_o | output | 1 | Second PDM data consumer |
| pwrdn_o | output | 1 | Record power-down consumer |
| bias_en_o | output | 1 | Bias enable consumer |
| gpi_mon_o | output | 1 | Synchronised input monitor |

## Verification
The assertions assume that cfg_func and cfg_drive are quasi-static configuration, and that pad_in, irq_in and pdmclk_in are known levels on every clock edge. The monitor-latency check also assumes that the role code stays constant across the two edges it compares. The stimulus follows these assumptions. It changes every input only at falling edges and holds the role code steady through each monitor sequence. It compares the combinational pad controls a few nanoseconds after each change.

// File: rtl/pinmux_pkg.sv
// Shared codes for the pin multiplexer.
// Assumes role and drive codes are fixed-width fields supplied by configuration logic.
package pinmux_pkg;

    localparam int FUNC_W   = 4;
    localparam int DRIVE_W  = 3;
    localparam int N_ROUTES = 6;

    // Bit positions in the input route vector
    localparam int RT_BIAS  = 0;
    localparam int RT_PWRDN = 1;
    localparam int RT_PDM1  = 2;
    localparam int RT_PDM0  = 3;
    localparam int RT_CHAIN = 4;
    localparam int RT_MCLK  = 5;

    typedef enum logic [FUNC_W-1:0] {
        FN_OFF    = 4'd0,
        FN_GPOUT  = 4'd1,
        FN_IRQ    = 4'd2,
        FN_PWRDN  = 4'd3,
        FN_PDMCLK = 4'd4,
        FN_BIAS   = 4'd5,
        FN_GPIN   = 4'd6,
        FN_MCLK   = 4'd7,
        FN_CHAIN  = 4'd8,
        FN_PDM0   = 4'd9,
        FN_PDM1   = 4'd10
    } pin_func_e;

    typedef enum logic [DRIVE_W-1:0] {
        DRV_FLOAT   = 3'd0,
        DRV_PUSH    = 3'd1,
        DRV_LO_PU   = 3'd2,
        DRV_LO_ONLY = 3'd3,
        DRV_PD_HI   = 3'd4,
        DRV_HI_ONLY = 3'd5
    } drive_e;

    typedef enum logic [1:0] {
        SRC_GPO = 2'd0,
        SRC_IRQ = 2'd1,
        SRC_PDM = 2'd2
    } out_src_e;

    typedef struct packed {
        logic oe;
        logic dout;
        logic pu;
        logic pd;
    } pad_ctrl_t;

endpackage

// File: rtl/pinmux_func_decode.sv
// Decodes the role code into an output/input role, an output source and a one-hot
// route selection. HAS_OUTPUT / HAS_INPUT remove roles the pin variant cannot serve;
// a removed or unassigned role decodes as disabled.
module pinmux_func_decode
    import pinmux_pkg::*;
#(
    parameter bit HAS_OUTPUT = 1'b1,
    parameter bit HAS_INPUT  = 1'b1
) (
    input  logic [FUNC_W-1:0]   func_i,
    output logic                out_role_o,
    output logic                in_role_o,
    output out_src_e            src_o,
    output logic [N_ROUTES-1:0] route_sel_o,
    output logic                mon_sel_o
);

    logic                out_role;
    logic                in_role;
    logic [N_ROUTES-1:0] route_sel;
    logic                mon_sel;

    // Raw role decode, before variant trimming
    always_comb begin
        out_role  = 1'b0;
        in_role   = 1'b0;
        src_o     = SRC_GPO;
        route_sel = '0;
        mon_sel   = 1'b0;
        case (pin_func_e'(func_i))
            FN_GPOUT:  out_role = 1'b1;
            FN_IRQ:    begin out_role = 1'b1; src_o = SRC_IRQ; end
            FN_PDMCLK: begin out_role = 1'b1; src_o = SRC_PDM; end
            FN_PWRDN:  begin in_role = 1'b1; route_sel[RT_PWRDN] = 1'b1; end
            FN_BIAS:   begin in_role = 1'b1; route_sel[RT_BIAS]  = 1'b1; end
            FN_MCLK:   begin in_role = 1'b1; route_sel[RT_MCLK]  = 1'b1; end
            FN_CHAIN:  begin in_role = 1'b1; route_sel[RT_CHAIN] = 1'b1; end
            FN_PDM0:   begin in_role = 1'b1; route_sel[RT_PDM0]  = 1'b1; end
            FN_PDM1:   begin in_role = 1'b1; route_sel[RT_PDM1]  = 1'b1; end
            FN_GPIN:   begin in_role = 1'b1; mon_sel = 1'b1; end
            default:   ;
        endcase
    end

    // Variant trimming chosen by parameters
    generate
        if (HAS_OUTPUT) begin : g_out
            assign out_role_o = out_role;
        end else begin : g_no_out
            assign out_role_o = 1'b0;
        end
        if (HAS_INPUT) begin : g_in
            assign in_role_o   = in_role;
            assign route_sel_o = route_sel;
            assign mon_sel_o   = mon_sel;
        end else begin : g_no_in
            assign in_role_o   = 1'b0;
            assign route_sel_o = '0;
            assign mon_sel_o   = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/pinmux_drive_encode.sv
// Turns a logical level and a drive code into pad controls.
// Assumes en_i is high only in an output role; with en_i low the pad floats.
module pinmux_drive_encode
    import pinmux_pkg::*;
(
    input  logic               en_i,
    input  logic               level_i,
    input  logic [DRIVE_W-1:0] drive_i,
    output pad_ctrl_t          ctrl_o
);

    // Per-code mapping of low/high level to strong, weak or floating
    always_comb begin
        ctrl_o = '0;
        if (en_i) begin
            case (drive_e'(drive_i))
                DRV_FLOAT: ;
                DRV_PUSH: begin
                    ctrl_o.oe   = 1'b1;
                    ctrl_o.dout = level_i;
                end
                DRV_LO_PU: begin
                    if (level_i) ctrl_o.pu = 1'b1;
                    else         ctrl_o.oe = 1'b1;
                end
                DRV_LO_ONLY: begin
                    if (!level_i) ctrl_o.oe = 1'b1;
                end
                DRV_PD_HI: begin
                    if (level_i) begin
                        ctrl_o.oe   = 1'b1;
                        ctrl_o.dout = 1'b1;
                    end else begin
                        ctrl_o.pd = 1'b1;
                    end
                end
                DRV_HI_ONLY: begin
                    if (level_i) begin
                        ctrl_o.oe   = 1'b1;
                        ctrl_o.dout = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pinmux_in_route.sv
// Passes the pad level to the selected consumer and feeds the monitor bit through a
// SYNC_STAGES-deep synchroniser. Assumes route_sel_i is one-hot or zero.
module pinmux_in_route
    import pinmux_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pad_i,
    input  logic [N_ROUTES-1:0] route_sel_i,
    input  logic                mon_sel_i,
    output logic [N_ROUTES-1:0] route_o,
    output logic                mon_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   mon_d;

    assign route_o = route_sel_i & {N_ROUTES{pad_i}};
    assign mon_d   = mon_sel_i & pad_i;
    assign mon_o   = sync_q[SYNC_STAGES-1];

    // Synchroniser shift chain for the monitor bit
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], mon_d};
    end

    // Never more than one consumer sees the pad
    assert_one_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(route_o));

    // Reset clears the monitor path
    assert_mon_reset_R11: assert property (@(posedge clk)
        !rst_n |=> !mon_o);

    generate
        if (SYNC_STAGES == 2) begin : g_lat_chk
            // Monitor follows the gated input two edges later
            assert_mon_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(rst_n, 2)) |-> (mon_o == $past(mon_d, 2)));
        end
    endgenerate

endmodule

// File: rtl/pinmux_pin.sv
// Top of one multifunction pin: role decode, output source mux, drive encoding and
// input routing. Assumes configuration is quasi-static and pad_in is a known level.
module pinmux_pin
    import pinmux_pkg::*;
#(
    parameter bit HAS_OUTPUT  = 1'b1,
    parameter bit HAS_INPUT   = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FUNC_W-1:0]  cfg_func,
    input  logic [DRIVE_W-1:0] cfg_drive,
    input  logic               gpo_val,
    input  logic               irq_in,
    input  logic               pdmclk_in,
    input  logic               pad_in,
    output logic               pad_oe,
    output logic               pad_out,
    output logic               pad_pu_en,
    output logic               pad_pd_en,
    output logic               mclk_o,
    output logic               chain_din_o,
    output logic               pdm_din0_o,
    output logic               pdm_din1_o,
    output logic               pwrdn_o,
    output logic               bias_en_o,
    output logic               gpi_mon_o
);

    logic                out_role;
    logic                in_role;
    out_src_e            src;
    logic [N_ROUTES-1:0] route_sel;
    logic                mon_sel;
    logic                level;
    pad_ctrl_t           ctrl;
    logic [N_ROUTES-1:0] route;

    pinmux_func_decode #(
        .HAS_OUTPUT (HAS_OUTPUT),
        .HAS_INPUT  (HAS_INPUT)
    ) u_decode (
        .func_i      (cfg_func),
        .out_role_o  (out_role),
        .in_role_o   (in_role),
        .src_o       (src),
        .route_sel_o (route_sel),
        .mon_sel_o   (mon_sel)
    );

    // Output source selection
    always_comb begin
        case (src)
            SRC_IRQ: level = irq_in;
            SRC_PDM: level = pdmclk_in;
            default: level = gpo_val;
        endcase
    end

    pinmux_drive_encode u_drive (
        .en_i    (out_role),
        .level_i (level),
        .drive_i (cfg_drive),
        .ctrl_o  (ctrl)
    );

    pinmux_in_route #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_route (
        .clk         (clk),
        .rst_n       (rst_n),
        .pad_i       (pad_in),
        .route_sel_i (route_sel),
        .mon_sel_i   (mon_sel),
        .route_o     (route),
        .mon_o       (gpi_mon_o)
    );

    assign pad_oe      = ctrl.oe;
    assign pad_out     = ctrl.dout;
    assign pad_pu_en   = ctrl.pu;
    assign pad_pd_en   = ctrl.pd;
    assign mclk_o      = route[RT_MCLK];
    assign chain_din_o = route[RT_CHAIN];
    assign pdm_din0_o  = route[RT_PDM0];
    assign pdm_din1_o  = route[RT_PDM1];
    assign pwrdn_o     = route[RT_PWRDN];
    assign bias_en_o   = route[RT_BIAS];

    // Pad is never both pulled up and pulled down
    assert_pulls_apart_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(pad_pu_en && pad_pd_en));

    // Strong data is low whenever the driver is off
    assert_quiet_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_oe |-> !pad_out);

    // An input role leaves the pad undriven and unpulled
    assert_input_undriven_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_role |-> (!pad_oe && !pad_pu_en && !pad_pd_en));

    // Reserved drive codes float the pad
    assert_reserved_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_drive[2:1] == 2'b11) |-> (!pad_oe && !pad_pu_en && !pad_pd_en));

    // A floating drive code never enables anything
    assert_float_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_drive == 3'b000) |-> (!pad_oe && !pad_pu_en && !pad_pd_en));

endmodule

// File: tb/pinmux_pin_bench.sv
module pinmux_pin_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cfg_func = 4'd0;
    logic [2:0] cfg_drive = 3'd0;
    logic       gpo_val = 1'b0, irq_in = 1'b0, pdmclk_in = 1'b0, pad_in = 1'b0;
    logic       pad_oe, pad_out, pad_pu_en, pad_pd_en;
    logic       mclk_o, chain_din_o, pdm_din0_o, pdm_din1_o, pwrdn_o, bias_en_o, gpi_mon_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pinmux_pin u_pinmux_pin (
        .clk(clk), .rst_n(rst_n), .cfg_func(cfg_func), .cfg_drive(cfg_drive),
        .gpo_val(gpo_val), .irq_in(irq_in), .pdmclk_in(pdmclk_in), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu_en(pad_pu_en), .pad_pd_en(pad_pd_en),
        .mclk_o(mclk_o), .chain_din_o(chain_din_o), .pdm_din0_o(pdm_din0_o),
        .pdm_din1_o(pdm_din1_o), .pwrdn_o(pwrdn_o), .bias_en_o(bias_en_o),
        .gpi_mon_o(gpi_mon_o)
    );

    // {func, drive, gpo irq pdm pad, oe out pu pd, mclk chain pdm0 pdm1 pwrdn bias, req}
    localparam int NV = 29;
    localparam logic [24:0] VEC [0:NV-1] = '{
        {4'd1, 3'd0, 4'b1000, 4'b0000, 6'b000000, 4'd1},   // R1
        {4'd1, 3'd0, 4'b0000, 4'b0000, 6'b000000, 4'd1},   // R1
        {4'd1, 3'd1, 4'b1000, 4'b1100, 6'b000000, 4'd2},   // R2
        {4'd1, 3'd1, 4'b0000, 4'b1000, 6'b000000, 4'd2},   // R2
        {4'd1, 3'd2, 4'b0000, 4'b1000, 6'b000000, 4'd3},   // R3
        {4'd1, 3'd2, 4'b1000, 4'b0010, 6'b000000, 4'd3},   // R3
        {4'd1, 3'd3, 4'b0000, 4'b1000, 6'b000000, 4'd4},   // R4
        {4'd1, 3'd3, 4'b1000, 4'b0000, 6'b000000, 4'd4},   // R4
        {4'd1, 3'd4, 4'b0000, 4'b0001, 6'b000000, 4'd5},   // R5
        {4'd1, 3'd4, 4'b1000, 4'b1100, 6'b000000, 4'd5},   // R5
        {4'd1, 3'd5, 4'b0000, 4'b0000, 6'b000000, 4'd5},   // R5
        {4'd1, 3'd5, 4'b1000, 4'b1100, 6'b000000, 4'd5},   // R5
        {4'd1, 3'd6, 4'b1000, 4'b0000, 6'b000000, 4'd6},   // R6
        {4'd1, 3'd7, 4'b0000, 4'b0000, 6'b000000, 4'd6},   // R6
        {4'd2, 3'd1, 4'b0100, 4'b1100, 6'b000000, 4'd7},   // R7
        {4'd2, 3'd1, 4'b1000, 4'b1000, 6'b000000, 4'd7},   // R7
        {4'd4, 3'd1, 4'b0010, 4'b1100, 6'b000000, 4'd7},   // R7
        {4'd4, 3'd1, 4'b0100, 4'b1000, 6'b000000, 4'd7},   // R7
        {4'd7, 3'd1, 4'b0001, 4'b0000, 6'b100000, 4'd8},   // R8
        {4'd8, 3'd1, 4'b0001, 4'b0000, 6'b010000, 4'd8},   // R8
        {4'd9, 3'd2, 4'b0001, 4'b0000, 6'b001000, 4'd8},   // R8
        {4'd10, 3'd1, 4'b0001, 4'b0000, 6'b000100, 4'd8},  // R8
        {4'd3, 3'd1, 4'b1001, 4'b0000, 6'b000010, 4'd8},   // R8
        {4'd5, 3'd4, 4'b0001, 4'b0000, 6'b000001, 4'd8},   // R8
        {4'd7, 3'd1, 4'b1110, 4'b0000, 6'b000000, 4'd8},   // R8
        {4'd6, 3'd1, 4'b1111, 4'b0000, 6'b000000, 4'd8},   // R8
        {4'd0, 3'd1, 4'b1111, 4'b0000, 6'b000000, 4'd9},   // R9
        {4'd11, 3'd1, 4'b1111, 4'b0000, 6'b000000, 4'd9},  // R9
        {4'd15, 3'd2, 4'b1111, 4'b0000, 6'b000000, 4'd9}   // R9
    };

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    initial begin
        #3_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // Reset state of the monitor (R11)
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R11", {9'd0, gpi_mon_o}, 10'd0);
        rst_n = 1'b1;

        // Table-driven combinational checks
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cfg_func  = VEC[i][24:21];
            cfg_drive = VEC[i][20:18];
            {gpo_val, irq_in, pdmclk_in, pad_in} = VEC[i][17:14];
            #2;
            check($sformatf("R%0d vec%0d", VEC[i][3:0], i),
                  {pad_oe, pad_out, pad_pu_en, pad_pd_en,
                   mclk_o, chain_din_o, pdm_din0_o, pdm_din1_o, pwrdn_o, bias_en_o},
                  VEC[i][13:4]);
            // R12 invariants on every vector
            check("R12", {8'd0, (pad_pu_en & pad_pd_en), (~pad_oe & pad_out)}, 10'd0);
        end

        // Monitor latency (R10)
        @(negedge clk);
        cfg_func = 4'd6; cfg_drive = 3'd1; pad_in = 1'b1;
        @(negedge clk);
        check("R10 one edge", {9'd0, gpi_mon_o}, 10'd0);
        @(negedge clk);
        check("R10 two edges", {9'd0, gpi_mon_o}, 10'd1);
        pad_in = 1'b0;
        @(negedge clk);
        check("R10 hold", {9'd0, gpi_mon_o}, 10'd1);
        @(negedge clk);
        check("R10 fall", {9'd0, gpi_mon_o}, 10'd0);

        // Monitor gated off in another role (R10)
        pad_in = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 rearm", {9'd0, gpi_mon_o}, 10'd1);
        cfg_func = 4'd7;
        repeat (2) @(negedge clk);
        check("R10 other role", {9'd0, gpi_mon_o}, 10'd0);
        check("R8 mclk live", {9'd0, mclk_o}, 10'd1);

        // Reset mid-run clears the monitor (R11)
        cfg_func = 4'd6;
        repeat (2) @(negedge clk);
        check("R11 pre", {9'd0, gpi_mon_o}, 10'd1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 cleared", {9'd0, gpi_mon_o}, 10'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 after", {9'd0, gpi_mon_o}, 10'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule